// File: doc/BRIEF.md
# Die-Temperature Overload Supervisor for a Four-Line Feeder

This block watches a digital die-temperature reading for a multi-channel line feeder and decides, channel by channel, whether each line driver is still allowed to conduct. It applies three temperature tiers, and each tier has a hysteresis band. The lowest tier, the admission tier, closes the door to new activation requests. The middle tier, the limit tier, trips channels that are sitting in current limit. The highest tier, the critical tier, trips every channel at once.

Each channel owns one "permit" flag, where high means the driver may be on, and one latch bit. When a channel trips while it is in current limit, or when it is active during a critical trip, its flag stays low until a switch-off command for that channel arrives. After that command, the flag rises only once the temperature is back below the matching release point. A flag that went low without being latched comes back by itself once the temperature has cooled enough.

All inputs are level signals sampled on each clock. All outputs come from registers, so there is no data stream and no handshake at the edge of the block.

Top module: `thermal_supervisor`

## Requirements
- R1: After reset, whether at start-up or from a reset pulse in mid-run, every permit flag is 1, no latch is held, `accept_new_o` is 1, `over_temp_o` is 0 and `force_off_o` is all zeros.
- R2: A temperature of 110 or more clears `accept_new_o`. It stays 0 while the temperature is above 100 and returns to 1 once the temperature is 100 or less. The tier state is registered, and the output follows one clock after the sample.
- R3: While the limit tier is active (set at 130 or more, cleared at 120 or less), a channel whose `cur_lim_i` bit is 1 has its permit flag driven to 0 and latched. Channels that are not in current limit keep their flags.
- R4: When `seq_en_i` is 0, a channel latched by the limit tier regains its flag after a switch-off command only once the temperature is 120 or less.
- R5: When `seq_en_i` is 1, that same channel regains its flag only once the temperature is 100 or less.
- R6: A latched flag stays 0 for as long as no switch-off command arrives for that channel, however far the temperature falls. A one-cycle pulse on that channel's bit of `off_cmd_i` releases the latch.
- R7: A temperature of 160 or more drives every permit flag to 0, and it latches only the channels whose `drv_on_i` bit was 1. A temperature of 159 trips nothing at this tier.
- R8: `over_temp_o` is 1 from a sample of 160 or more until a sample of 150 or less. When it clears, the unlatched flags rise again by themselves, while the latched flags wait for a switch-off command.
- R9: `force_off_o` bit n is always the inverse of permit flag n.
- R10: When a trip and a switch-off command hit the same channel in the same cycle, the trip wins and the flag is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets all flags high |
| temp_i | input | TW (8) | Die temperature in whole degrees Celsius, unsigned |
| seq_en_i | input | 1 | 1 = power-on sequencer in use (selects the lower release point) |
| cur_lim_i | input | NCH (4) | Per-channel in-current-limit status |
| drv_on_i | input | NCH (4) | Per-channel driver-active status |
| off_cmd_i | input | NCH (4) | Per-channel switch-off command (clears the latch) |
| ovl_flag_o | output | NCH (4) | Per-channel permit flag, 1 = driver may be on |
| accept_new_o | output | 1 | 1 = new activation requests may be accepted |
| force_off_o | output | NCH (4) | Per-channel forced switch-off mask |
| over_temp_o | output | 1 | Read-only critical over-temperature bit |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit temperature, and tiers at 110, 130 and 160 with a band of 10. Because the temperature is in whole degrees, every set and release edge can be hit exactly, for example 109 against 110, 101 against 100, 121 against 120, 151 against 150 and 159 against 160. The stimulus walks each tier up and down while toggling the sequencer-enable input, the current-limit bits and the active bits. This exposes the choice of release point, latched against unlatched recovery, and the case where a trip and a switch-off command arrive in the same cycle.

// File: rtl/tsup_pkg.sv
package tsup_pkg;
  localparam int NUM_TIERS = 3;
  localparam int TIER_GATE = 0;
  localparam int TIER_LIMIT = 1;
  localparam int TIER_CRIT = 2;

  typedef struct packed {
    logic crit;
    logic limit;
    logic gate;
  } tier_hot_t;
endpackage

// File: rtl/tsup_hyst_cmp.sv
module tsup_hyst_cmp #(
  parameter int TW   = 8,
  parameter int TRIP = 110,
  parameter int HYST = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_i,
  output logic          hot_o
);
  localparam logic [TW-1:0] TRIP_V = TW'(TRIP);
  localparam logic [TW-1:0] REL_V  = TW'(TRIP - HYST);

  logic hot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hot_q <= 1'b0;
    else if (temp_i >= TRIP_V) hot_q <= 1'b1;
    else if (temp_i <= REL_V)  hot_q <= 1'b0;
  end

  assign hot_o = hot_q;

  // R2, R3, R8: tier set and release points
  a_r2_tier_set: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i >= TRIP_V) |=> hot_o);
  a_r2_tier_release: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i <= REL_V) |=> !hot_o);
  a_r8_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i > REL_V && temp_i < TRIP_V) |=> $stable(hot_o));
endmodule

// File: rtl/tsup_chan_flag.sv
module tsup_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_hot_i,
  input  logic limit_hot_i,
  input  logic crit_hot_i,
  input  logic seq_en_i,
  input  logic cur_lim_i,
  input  logic drv_on_i,
  input  logic off_cmd_i,
  output logic flag_o
);
  logic flag_q, latch_q, cause_crit_q;
  logic trip_crit, trip_lim, release_ok;

  assign trip_crit = crit_hot_i;
  assign trip_lim  = limit_hot_i & cur_lim_i;

  always_comb begin
    if (crit_hot_i)        release_ok = 1'b0;
    else if (cause_crit_q) release_ok = 1'b1;
    else if (seq_en_i)     release_ok = !gate_hot_i;
    else                   release_ok = !limit_hot_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q       <= 1'b1;
      latch_q      <= 1'b0;
      cause_crit_q <= 1'b0;
    end else if (trip_crit) begin
      flag_q       <= 1'b0;
      latch_q      <= latch_q | drv_on_i;
      cause_crit_q <= 1'b1;
    end else if (trip_lim) begin
      flag_q       <= 1'b0;
      latch_q      <= 1'b1;
      cause_crit_q <= 1'b0;
    end else begin
      if (off_cmd_i) latch_q <= 1'b0;
      if (!flag_q && !latch_q && release_ok) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  a_r6_latched_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> !flag_o);
  a_r3_limit_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_hot_i && cur_lim_i && !crit_hot_i) |=> (!flag_o && latch_q));
  a_r7_crit_trip: assert property (@(posedge clk) disable iff (!rst_n)
    crit_hot_i |=> !flag_o);
  a_r10_trip_beats_off: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_lim && off_cmd_i && !crit_hot_i) |=> latch_q);
  a_r8_rise_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> (!$past(latch_q) && !$past(crit_hot_i)));
endmodule

// File: rtl/thermal_supervisor.sv
module thermal_supervisor #(
  parameter int NCH        = 4,
  parameter int TW         = 8,
  parameter int T_GATE     = 110,
  parameter int T_LIMIT    = 130,
  parameter int T_CRIT     = 160,
  parameter int HYST       = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  temp_i,
  input  logic           seq_en_i,
  input  logic [NCH-1:0] cur_lim_i,
  input  logic [NCH-1:0] drv_on_i,
  input  logic [NCH-1:0] off_cmd_i,
  output logic [NCH-1:0] ovl_flag_o,
  output logic           accept_new_o,
  output logic [NCH-1:0] force_off_o,
  output logic           over_temp_o
);
  import tsup_pkg::*;

  localparam int TRIP_TAB [NUM_TIERS] = '{T_GATE, T_LIMIT, T_CRIT};

  logic [NUM_TIERS-1:0] hot;
  tier_hot_t            tiers;
  logic [NCH-1:0]       flags;

  for (genvar g = 0; g < NUM_TIERS; g++) begin : g_tier
    tsup_hyst_cmp #(.TW(TW), .TRIP(TRIP_TAB[g]), .HYST(HYST)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .temp_i (temp_i),
      .hot_o  (hot[g])
    );
  end

  assign tiers.gate  = hot[TIER_GATE];
  assign tiers.limit = hot[TIER_LIMIT];
  assign tiers.crit  = hot[TIER_CRIT];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tsup_chan_flag u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .gate_hot_i  (tiers.gate),
      .limit_hot_i (tiers.limit),
      .crit_hot_i  (tiers.crit),
      .seq_en_i    (seq_en_i),
      .cur_lim_i   (cur_lim_i[c]),
      .drv_on_i    (drv_on_i[c]),
      .off_cmd_i   (off_cmd_i[c]),
      .flag_o      (flags[c])
    );
  end

  assign ovl_flag_o   = flags;
  assign force_off_o  = ~flags;
  assign accept_new_o = ~tiers.gate;
  assign over_temp_o  = tiers.crit;

  a_r7_all_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_temp_o) |=> (&force_off_o));
  a_r2_gate_closed_when_hot: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp_o |-> !accept_new_o);
  a_r9_mask_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(force_off_o & ovl_flag_o) == 0);
endmodule

// File: tb/thermal_supervisor_tb.sv
module thermal_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  typedef struct {
    logic [NCH-1:0] flags;
    logic           acc;
    logic           ovt;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     temp = 8'd25;
  logic           seq_en = 1'b0;
  logic [NCH-1:0] lim = '0, on = '0, off = '0;
  logic [NCH-1:0] flags, force_off;
  logic           acc, ovt;

  int   errors = 0, checks = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_supervisor u_dut (
    .clk (clk), .rst_n (rst_n), .temp_i (temp), .seq_en_i (seq_en),
    .cur_lim_i (lim), .drv_on_i (on), .off_cmd_i (off),
    .ovl_flag_o (flags), .accept_new_o (acc), .force_off_o (force_off),
    .over_temp_o (ovt)
  );

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (flags !== e.flags || acc !== e.acc || ovt !== e.ovt) begin
          errors++;
          $display("FAIL %s: flags=%b acc=%b ovt=%b expected flags=%b acc=%b ovt=%b",
                   e.tag, flags, acc, ovt, e.flags, e.acc, e.ovt);
        end
        checks++;
        if (force_off !== ~e.flags) begin
          errors++;
          $display("FAIL R9 (%s): force_off=%b expected %b", e.tag, force_off, ~e.flags);
        end
      end
    end
  end

  task automatic expect_now(input logic [NCH-1:0] f, input logic a, input logic t,
                            input string tag);
    exp_t e;
    e.flags = f; e.acc = a; e.ovt = t; e.tag = tag;
    @(posedge clk);
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic step(input logic [7:0] t);
    temp = t;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_off(input logic [NCH-1:0] m);
    off = m;
    @(negedge clk);
    off = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic trip_lim(input logic [NCH-1:0] m);
    step(8'd130);
    lim = m;
    repeat (3) @(negedge clk);
    lim = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(4'b1111, 1'b1, 1'b0, "R1 reset state");

    step(8'd109); expect_now(4'b1111, 1'b1, 1'b0, "R2 109 below gate");
    step(8'd110); expect_now(4'b1111, 1'b0, 1'b0, "R2 110 closes gate");
    step(8'd101); expect_now(4'b1111, 1'b0, 1'b0, "R2 101 still closed");
    step(8'd100); expect_now(4'b1111, 1'b1, 1'b0, "R2 100 reopens");

    trip_lim(4'b0010);
    expect_now(4'b1101, 1'b0, 1'b0, "R3 limit trip ch1 only");
    pulse_off(4'b0010);
    step(8'd125); expect_now(4'b1101, 1'b0, 1'b0, "R4 125 no release");
    step(8'd121); expect_now(4'b1101, 1'b0, 1'b0, "R4 121 no release");
    step(8'd120); expect_now(4'b1111, 1'b0, 1'b0, "R4 120 releases");

    seq_en = 1'b1;
    trip_lim(4'b0010);
    pulse_off(4'b0010);
    step(8'd110); expect_now(4'b1101, 1'b0, 1'b0, "R5 seq 110 no release");
    step(8'd101); expect_now(4'b1101, 1'b0, 1'b0, "R5 seq 101 no release");
    step(8'd100); expect_now(4'b1111, 1'b1, 1'b0, "R5 seq 100 releases");
    seq_en = 1'b0;

    trip_lim(4'b0100);
    step(8'd90); expect_now(4'b1011, 1'b1, 1'b0, "R6 latch held when cool");
    pulse_off(4'b0100); expect_now(4'b1111, 1'b1, 1'b0, "R6 off releases latch");

    step(8'd130);
    lim = 4'b1000; off = 4'b1000;
    @(negedge clk);
    lim = '0; off = '0;
    step(8'd90); expect_now(4'b0111, 1'b1, 1'b0, "R10 trip wins over off");
    pulse_off(4'b1000); expect_now(4'b1111, 1'b1, 1'b0, "R10 later off releases");

    step(8'd159); expect_now(4'b1111, 1'b0, 1'b0, "R7 159 no crit trip");
    on = 4'b0101;
    step(8'd160); expect_now(4'b0000, 1'b0, 1'b1, "R7 160 trips all");
    on = '0;
    step(8'd151); expect_now(4'b0000, 1'b0, 1'b1, "R8 151 still hot");
    step(8'd150); expect_now(4'b1010, 1'b0, 1'b0, "R8 150 unlatched back");
    pulse_off(4'b0101); expect_now(4'b1111, 1'b0, 1'b0, "R8 latched back on off");
    step(8'd90); expect_now(4'b1111, 1'b1, 1'b0, "R2 cool reopens");

    trip_lim(4'b0001);
    expect_now(4'b1110, 1'b0, 1'b0, "R3 trip ch0");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    temp = 8'd25;
    @(negedge clk);
    expect_now(4'b1111, 1'b1, 1'b0, "R1 reset pulse restores");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule